// File: doc/BRIEF.md
# Command Slot Issue and Active Tracking Registers

This block keeps, for each port of a multi-port serial storage host controller, two 32-bit slot vectors. The "active" vector marks queued commands that the device has not yet reported complete. The "issue" vector marks commands that software has built in memory and that the port may send. Software sets bits through a simple register bus. The bits are cleared by events the port engine reports:
- a Set Device Bits FIS, which carries a mask of finished queued slots;
- a device-to-host register FIS, which drops BSY, ERR and DRQ for one slot;
- a falling port start bit.

Both vectors are driven out on every cycle to the command fetch logic. A link reset or a device soft reset does not touch them. Only the global synchronous reset and a 1-to-0 change of the start bit return them to zero.

The register bus uses byte addresses. Writes take effect at the clock edge. The read data port is registered: it shows, one cycle later, the value the addressed register held before that edge.

Top module: `cmdslot_regs`

## Requirements
- R1: While `rst` is high at a clock edge, every active and issue vector, every stored start bit and `bus_rdata` become zero.
- R2: Port p's active register is at byte address 134h + 80h*p and its issue register at 138h + 80h*p. `bus_rdata` after an edge equals the value the register at `bus_addr` held just before that edge.
- R3: A write (`bus_wr_en` high) to a register sets every bit where `bus_wdata` is 1. Bits where `bus_wdata` is 0 keep their value, and no bit is set by anything but a write.
- R4: When `sdb_valid[p]` is high, every active bit of port p whose `sdb_mask` bit is 1 is zero after the edge. Other active bits are unaffected.
- R5: When `d2h_clr_valid[p]` is high, issue bit number `d2h_clr_slot[p]` (5-bit index, slot 0 = bit 0) of port p is zero after the edge.
- R6: If a software set and a hardware clear target the same bit in one cycle, the bit is zero after the edge.
- R7: The first edge at which `port_start[p]` is 0, after an edge at which it was 1, leaves both vectors of port p at zero. This overrides any write or clear in that cycle, and other ports are unaffected.
- R8: A start bit that stays 0 or rises from 0 to 1 clears nothing, and writes still set bits while it is 0.
- R9: Writes to any address other than the defined registers change no register, and reads of such addresses return zero.
- R10: `active_vec` and `issue_vec` show port p's registers in bits [32p+31:32p] after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 32 | Write data, 1 bits set slots |
| bus_rdata | output | 32 | Registered read data |
| port_start | input | 2 | Per-port start bit |
| sdb_valid | input | 2 | Set Device Bits FIS received, per port |
| sdb_mask | input | 64 | Slots cleared by that FIS, 32 per port |
| d2h_clr_valid | input | 2 | Register FIS cleared BSY/ERR/DRQ, per port |
| d2h_clr_slot | input | 10 | Slot index of that FIS, 5 bits per port |
| issue_vec | output | 64 | Issue vectors, 32 per port |
| active_vec | output | 64 | Active vectors, 32 per port |

## Verification
The hardest case to reach is a collision of three updates on one port in one cycle: a start-bit fall, a software write and both hardware clears. A second collision is a software set and a hardware clear on the same bit. Directed phases first fill both ports through the bus. They then drop one port's start bit while writing and clearing that same port, and while the other port keeps its contents. A long random phase follows that toggles the start bits, aims writes at valid and near-miss addresses, and fires both FIS kinds at once. A cycle-by-cycle reference model checks every edge.

// File: rtl/cmdslot_pkg.sv
package cmdslot_pkg;

  function automatic logic [31:0] slot_onehot(input logic [4:0] idx);
    logic [31:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/cmdslot_addr_dec.sv
module cmdslot_addr_dec #(
  parameter int NPORTS      = 2,
  parameter int ADDR_W      = 12,
  parameter int PORT_BASE   = 'h100,
  parameter int PORT_STRIDE = 'h80,
  parameter int ACT_OFS     = 'h34,
  parameter int ISS_OFS     = 'h38
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NPORTS-1:0] act_sel,
  output logic [NPORTS-1:0] iss_sel,
  output logic              hit
);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] ACT_ADDR = ADDR_W'(PORT_BASE + p*PORT_STRIDE + ACT_OFS);
    localparam logic [ADDR_W-1:0] ISS_ADDR = ADDR_W'(PORT_BASE + p*PORT_STRIDE + ISS_OFS);
    assign act_sel[p] = (addr == ACT_ADDR);
    assign iss_sel[p] = (addr == ISS_ADDR);
  end

  assign hit = |{act_sel, iss_sel};

endmodule

// File: rtl/cmdslot_fall_det.sv
module cmdslot_fall_det #(
  parameter int NPORTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] start,
  output logic [NPORTS-1:0] fall
);

  logic [NPORTS-1:0] start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= '0;
    else     start_q <= start;
  end

  assign fall = start_q & ~start;

endmodule

// File: rtl/cmdslot_port_bank.sv
module cmdslot_port_bank
  import cmdslot_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic [SLOTS-1:0]  act_set,
  input  logic [SLOTS-1:0]  iss_set,
  input  logic              sdb_valid,
  input  logic [SLOTS-1:0]  sdb_mask,
  input  logic              d2h_valid,
  input  logic [SLOT_W-1:0] d2h_slot,
  output logic [SLOTS-1:0]  act_q,
  output logic [SLOTS-1:0]  iss_q
);

  logic [SLOTS-1:0] act_clr;
  logic [SLOTS-1:0] iss_clr;

  always_comb begin
    act_clr = sdb_valid ? sdb_mask : '0;
    iss_clr = '0;
    if (d2h_valid) iss_clr[d2h_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || fall) begin
      act_q <= '0;
      iss_q <= '0;
    end else begin
      act_q <= (act_q | act_set) & ~act_clr;
      iss_q <= (iss_q | iss_set) & ~iss_clr;
    end
  end

  // R3: no bit rises without a software set behind it
  p_set_only_by_sw_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((act_q & ~$past(act_q) & ~$past(act_set)) == '0) &&
              ((iss_q & ~$past(iss_q) & ~$past(iss_set)) == '0)));

  p_sdb_clears_r4: assert property (@(posedge clk) disable iff (rst)
    sdb_valid |=> ((act_q & $past(sdb_mask)) == '0));

  p_d2h_clears_r5: assert property (@(posedge clk) disable iff (rst)
    d2h_valid |=> (iss_q[$past(d2h_slot)] == 1'b0));

  p_hw_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (|(act_set & sdb_mask) && sdb_valid) |=> ((act_q & $past(act_set & sdb_mask)) == '0));

  p_fall_clears_r7: assert property (@(posedge clk) disable iff (rst)
    fall |=> (act_q == '0 && iss_q == '0));

endmodule

// File: rtl/cmdslot_regs.sv
module cmdslot_regs
  import cmdslot_pkg::*;
#(
  parameter int NPORTS      = 2,
  parameter int SLOTS       = 32,
  parameter int ADDR_W      = 12,
  parameter int PORT_BASE   = 'h100,
  parameter int PORT_STRIDE = 'h80,
  parameter int ACT_OFS     = 'h34,
  parameter int ISS_OFS     = 'h38,
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr_en,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [SLOTS-1:0]         bus_wdata,
  output logic [SLOTS-1:0]         bus_rdata,
  input  logic [NPORTS-1:0]        port_start,
  input  logic [NPORTS-1:0]        sdb_valid,
  input  logic [NPORTS*SLOTS-1:0]  sdb_mask,
  input  logic [NPORTS-1:0]        d2h_clr_valid,
  input  logic [NPORTS*SLOT_W-1:0] d2h_clr_slot,
  output logic [NPORTS*SLOTS-1:0]  issue_vec,
  output logic [NPORTS*SLOTS-1:0]  active_vec
);

  logic [NPORTS-1:0] act_sel;
  logic [NPORTS-1:0] iss_sel;
  logic              addr_hit;
  logic [NPORTS-1:0] fall;
  logic [SLOTS-1:0]  act_q [NPORTS];
  logic [SLOTS-1:0]  iss_q [NPORTS];
  logic [SLOTS-1:0]  rd_mux;

  cmdslot_addr_dec #(
    .NPORTS(NPORTS), .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE),
    .PORT_STRIDE(PORT_STRIDE), .ACT_OFS(ACT_OFS), .ISS_OFS(ISS_OFS)
  ) u_dec (
    .addr(bus_addr), .act_sel(act_sel), .iss_sel(iss_sel), .hit(addr_hit)
  );

  cmdslot_fall_det #(.NPORTS(NPORTS)) u_fall (
    .clk(clk), .rst(rst), .start(port_start), .fall(fall)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_bank
    logic [SLOTS-1:0] act_set;
    logic [SLOTS-1:0] iss_set;
    assign act_set = (bus_wr_en && act_sel[p]) ? bus_wdata : '0;
    assign iss_set = (bus_wr_en && iss_sel[p]) ? bus_wdata : '0;

    cmdslot_port_bank #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_bank (
      .clk(clk), .rst(rst), .fall(fall[p]),
      .act_set(act_set), .iss_set(iss_set),
      .sdb_valid(sdb_valid[p]), .sdb_mask(sdb_mask[p*SLOTS +: SLOTS]),
      .d2h_valid(d2h_clr_valid[p]), .d2h_slot(d2h_clr_slot[p*SLOT_W +: SLOT_W]),
      .act_q(act_q[p]), .iss_q(iss_q[p])
    );

    assign active_vec[p*SLOTS +: SLOTS] = act_q[p];
    assign issue_vec[p*SLOTS +: SLOTS]  = iss_q[p];
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (act_sel[p]) rd_mux = rd_mux | act_q[p];
      if (iss_sel[p]) rd_mux = rd_mux | iss_q[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  p_onehot_sel_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act_sel, iss_sel}));

  p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !addr_hit |=> (bus_rdata == '0));

  p_miss_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && !addr_hit) |=> (active_vec & ~$past(active_vec)) == '0 &&
                                 (issue_vec & ~$past(issue_vec)) == '0);

endmodule

// File: tb/cmdslot_regs_test.sv
module cmdslot_regs_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr_en;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  port_start;
  logic [1:0]  sdb_valid;
  logic [63:0] sdb_mask;
  logic [1:0]  d2h_clr_valid;
  logic [9:0]  d2h_clr_slot;
  logic [63:0] issue_vec;
  logic [63:0] active_vec;

  always #5 clk = ~clk;

  cmdslot_regs uut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_start(port_start),
    .sdb_valid(sdb_valid), .sdb_mask(sdb_mask), .d2h_clr_valid(d2h_clr_valid),
    .d2h_clr_slot(d2h_clr_slot), .issue_vec(issue_vec), .active_vec(active_vec)
  );

  // reference model state
  logic [31:0] m_act [2];
  logic [31:0] m_iss [2];
  logic        m_sq  [2];
  logic [31:0] m_rd;
  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  function automatic logic [11:0] a_act(int p); return 12'(32'h134 + 32'h80*p); endfunction
  function automatic logic [11:0] a_iss(int p); return 12'(32'h138 + 32'h80*p); endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 2; p++) begin m_act[p] = 0; m_iss[p] = 0; m_sq[p] = 0; end
      m_rd = 0;
    end else begin
      logic [31:0] rd_n;
      rd_n = 0;
      for (int p = 0; p < 2; p++) begin
        if (bus_addr == a_act(p)) rd_n = m_act[p];
        if (bus_addr == a_iss(p)) rd_n = m_iss[p];
      end
      for (int p = 0; p < 2; p++) begin
        if (m_sq[p] && !port_start[p]) begin
          m_act[p] = 0;
          m_iss[p] = 0;
        end else begin
          if (bus_wr_en && bus_addr == a_act(p)) m_act[p] = m_act[p] | bus_wdata;
          if (bus_wr_en && bus_addr == a_iss(p)) m_iss[p] = m_iss[p] | bus_wdata;
          if (sdb_valid[p]) m_act[p] = m_act[p] & ~sdb_mask[p*32 +: 32];
          if (d2h_clr_valid[p]) m_iss[p][d2h_clr_slot[p*5 +: 5]] = 1'b0;
        end
        m_sq[p] = port_start[p];
      end
      m_rd = rd_n;
    end
  end

  task automatic cmp(string what, logic [31:0] got, logic [31:0] exp);
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done && m_rd !== 32'bx) begin
      n_vec++;
      cmp("rdata", bus_rdata, m_rd);
      for (int p = 0; p < 2; p++) begin
        cmp($sformatf("active[%0d]", p), active_vec[p*32 +: 32], m_act[p]);
        cmp($sformatf("issue[%0d]", p),  issue_vec[p*32 +: 32],  m_iss[p]);
      end
    end
  end

  task automatic idle();
    bus_wr_en = 0; sdb_valid = 0; d2h_clr_valid = 0;
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a);
    bus_addr = a;
    step(2);
  endtask

  initial begin
    rst = 1; bus_wr_en = 0; bus_addr = 0; bus_wdata = 0; port_start = 0;
    sdb_valid = 0; sdb_mask = 0; d2h_clr_valid = 0; d2h_clr_slot = 0;
    step(4);
    cur_req = "R1";
    cmp("reset rdata R1", bus_rdata, 0);
    cmp("reset active R1", active_vec[31:0], 0);
    rst = 0;
    port_start = 2'b11;
    step(2);

    cur_req = "R2";
    wr(12'h134, 32'h0000_00F1);
    wr(12'h138, 32'h0000_0F02);
    wr(12'h1B4, 32'h00F0_0004);
    wr(12'h1B8, 32'h8000_0008);
    rd(12'h134); rd(12'h138); rd(12'h1B4); rd(12'h1B8);

    cur_req = "R3";
    wr(12'h134, 32'h0000_0000);
    wr(12'h134, 32'hA000_0100);
    rd(12'h134);

    cur_req = "R4";
    sdb_valid = 2'b01; sdb_mask = {32'hFFFF_FFFF, 32'h0000_00F0};
    step(); idle();
    sdb_valid = 2'b10; sdb_mask = {32'h00F0_0000, 32'h0};
    step(); idle();

    cur_req = "R5";
    d2h_clr_valid = 2'b11; d2h_clr_slot = {5'd31, 5'd1};
    step(); idle();
    d2h_clr_valid = 2'b01; d2h_clr_slot = {5'd0, 5'd9};
    step(); idle();

    cur_req = "R6";
    bus_wr_en = 1; bus_addr = 12'h134; bus_wdata = 32'h0000_0F0F;
    sdb_valid = 2'b01; sdb_mask = {32'h0, 32'h0000_0F00};
    step(); idle();
    bus_wr_en = 1; bus_addr = 12'h1B8; bus_wdata = 32'h0001_0001;
    d2h_clr_valid = 2'b10; d2h_clr_slot = {5'd16, 5'd0};
    step(); idle();

    cur_req = "R7";
    wr(12'h1B4, 32'h1234_5678);
    port_start = 2'b01;
    bus_wr_en = 1; bus_addr = 12'h1B8; bus_wdata = 32'hFFFF_0000;
    sdb_valid = 2'b10; sdb_mask = '1;
    step(); idle();
    step(2);

    cur_req = "R8";
    wr(12'h1B4, 32'h0000_00AA);
    wr(12'h1B8, 32'h0000_0055);
    step(3);
    port_start = 2'b11;
    step(3);

    cur_req = "R9";
    wr(12'h130, 32'hFFFF_FFFF);
    wr(12'h13C, 32'hFFFF_FFFF);
    wr(12'h234, 32'hFFFF_FFFF);
    wr(12'h034, 32'hFFFF_FFFF);
    rd(12'h130); rd(12'h238); rd(12'h1B6);

    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] addrs [8];
      addrs = '{12'h134, 12'h138, 12'h1B4, 12'h1B8, 12'h135, 12'h234, 12'h0B8, 12'h1BC};
      bus_wr_en = ($urandom % 3) == 0;
      bus_addr = addrs[$urandom % 8];
      bus_wdata = $urandom & $urandom;
      sdb_valid = 2'($urandom) & 2'($urandom);
      sdb_mask = {$urandom, $urandom};
      d2h_clr_valid = 2'($urandom);
      d2h_clr_slot = 10'($urandom);
      if (($urandom % 40) == 0) port_start[$urandom % 2] ^= 1'b1;
      step();
    end
    idle();
    step(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule